// File: doc/BRIEF.md
# DDR3 Write Burst Strobe Sequencer

This block is the controller-side write data path of a DDR3 memory interface. It takes a write command together with the whole burst payload (eight data beats and eight mask beats), waits out the write latency, and then drives the data-strobe pair. The strobe goes through a preamble clock, four toggling clocks that carry two beats each, and a postamble clock. The block chooses per command between a full eight-beat burst and a four-beat chop. When a burst ends it runs a per-bank write-recovery count and reports, bank by bank, when a precharge may be issued.

Outputs are modelled per half clock. For `dqs` and `dqsN`, bit 0 is the value in the first half of the clock period and bit 1 the value in the second half. `dqEven`/`dmEven` is the beat launched against the rising strobe edge at the start of the period, and `dqOdd`/`dmOdd` is the beat launched against the falling edge in the middle. A mask bit of 1 means "do not write". Beat i of the payload sits at `wrData[i*DQ_W +: DQ_W]` and at `wrMask[i*DM_W +: DM_W]`.

A command is accepted on a rising clock edge where both `wrCmd` and `wrReady` are high. "Period n" means the clock period that begins n rising edges after that accepting edge.

Top module: `ddr_wr_burst_seq`

## Requirements
- R1: While reset is asserted and right after it, `dqsOe` and `dqOe` are 0, `dqs` and `dqsN` are 00, both data beats are 0, both mask beats are all ones, `wrReady` is 1 and every bit of `pchReady` is 1.
- R2: A command is a four-beat chop only when `burstField` equals binary 01 and `addr12` is 0. Every other combination produces a full eight-beat burst in which all eight payload beats are presented.
- R3: In period WL-1 (the preamble), `dqs` is 01 (high in the first half, low in the second half), the strobe and data enables are 1, and no beat is presented (data 0, mask all ones).
- R4: In periods WL+j, for j = 0..3, `dqs` is 01. `dqEven`/`dmEven` carry payload beat 2j and `dqOdd`/`dmOdd` carry payload beat 2j+1.
- R5: In period WL+4 (the postamble), `dqs` is 00 with both enables still 1 and no beat presented. The enables drop in period WL+5 unless a new preamble starts there.
- R6: `dqsOe` and `dqOe` are 1 exactly in the periods from preamble through postamble. `dqsN` is the bitwise inverse of `dqs` while enabled and 00 otherwise.
- R7: For a chopped burst, the strobe keeps the full four-period toggling pattern. Beats 4 to 7 (periods WL+2 and WL+3) are presented as data 0 with mask all ones.
- R8: After an accepted command, `wrReady` is 0 in periods 0 to 3 and 1 again in period 4. A `wrCmd` raised while `wrReady` is 0 is ignored and produces no burst.
- R9: When commands are accepted exactly five edges apart, the new command's preamble takes the place of the previous command's postamble in the same period, and the enables stay 1 without a gap.
- R10: `pchReady[b]` is 0 from period 0 through period WL+3+WR after a command to bank b, and 1 from period WL+4+WR onward. Commands to other banks do not affect it.
- R11: Outside the preamble-to-postamble window, `dqs` and `dqsN` are 00, the data beats are 0 and the mask beats are all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrCmd | input | 1 | Write command request |
| wrBank | input | BANK_W | Target bank of the write |
| burstField | input | 2 | Mode-register burst field |
| addr12 | input | 1 | On-the-fly burst-length address bit |
| wrData | input | 8*DQ_W | Eight data beats, beat 0 in the low bits |
| wrMask | input | 8*DM_W | Eight mask beats, beat 0 in the low bits |
| wrReady | output | 1 | Command can be accepted this clock |
| dqs | output | 2 | Strobe value, bit 0 first half, bit 1 second half |
| dqsN | output | 2 | Complementary strobe value |
| dqsOe | output | 1 | Strobe driver enable |
| dqOe | output | 1 | Data and mask driver enable |
| dqEven | output | DQ_W | Beat launched on the rising strobe edge |
| dqOdd | output | DQ_W | Beat launched on the falling strobe edge |
| dmEven | output | DM_W | Mask for the rising-edge beat |
| dmOdd | output | DM_W | Mask for the falling-edge beat |
| pchReady | output | 2**BANK_W | Per-bank precharge permitted |

## Verification
The bench targets the chop decode with all four combinations of the burst field and the address bit. A wrong decode either shows payload beats 4 to 7 on a chopped burst or masks them on a full one. It spaces commands exactly five edges apart, so the preamble must override the postamble. A design that lets the postamble win would show `dqs` 00 where 01 is due, or would drop the enables for a clock. It also raises commands inside the refusal window, where a leaky acceptance check would start an extra burst. It follows each bank's recovery window to its last clock, where an off-by-one counter opens precharge one period early or late.

// File: rtl/ddr_wr_pkg.sv
package ddr_wr_pkg;

  // Strobes sent from the control to the datapath for the current clock period.
  typedef struct packed {
    logic       capture;  // latch a new payload into the latency line
    logic       launch;   // preamble period: move payload into the burst register
    logic       beatOn;   // a data period of a burst is active
    logic [1:0] pair;     // which beat pair (0..3) is presented
    logic       chop;     // active burst is a four-beat chop
  } dpStrobe_t;

  localparam int BEATS      = 8;
  localparam int BURST_CLKS = BEATS / 2;

endpackage

// File: rtl/ddr_wr_ctrl.sv
module ddr_wr_ctrl
  import ddr_wr_pkg::*;
#(
  parameter  int WL     = 5,
  parameter  int WR     = 10,
  parameter  int BANK_W = 3,
  localparam int NB     = 1 << BANK_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrCmd,
  input  logic [BANK_W-1:0] wrBank,
  input  logic [1:0]        burstField,
  input  logic              addr12,
  output logic              wrReady,
  output logic [1:0]        dqs,
  output logic [1:0]        dqsN,
  output logic              dqsOe,
  output logic              dqOe,
  output logic [NB-1:0]     pchReady,
  output dpStrobe_t         strobes
);

  localparam int DEPTH  = WL + BURST_CLKS + 1;  // token stages: slot 0 .. postamble
  localparam int PRE_AT = WL - 1;
  localparam int END_AT = WL + BURST_CLKS - 1;  // last data period
  localparam int POST_AT = WL + BURST_CLKS;
  localparam int CW     = $clog2(WR + 1);
  localparam int GW     = $clog2(BURST_CLKS + 1);

  logic              pipeV [DEPTH];
  logic              pipeC [DEPTH];
  logic [BANK_W-1:0] pipeB [DEPTH];
  logic [GW-1:0]     gapCnt;
  logic              accept;
  logic              chopNew;
  logic              pre, post, beatOn, curChop;
  logic [1:0]        pair;

  assign accept  = wrCmd && wrReady;
  assign chopNew = (burstField == 2'b01) && !addr12;
  assign wrReady = (gapCnt == '0);

  // Refusal window: the next command may come once its data lands after the postamble.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       gapCnt <= '0;
    else if (accept) gapCnt <= GW'(BURST_CLKS);
    else if (gapCnt != '0) gapCnt <= gapCnt - 1'b1;
  end

  // Latency line of command tokens; stage k is valid in the k-th period after acceptance.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < DEPTH; k++) begin
        pipeV[k] <= 1'b0;
        pipeC[k] <= 1'b0;
        pipeB[k] <= '0;
      end
    end else begin
      pipeV[0] <= accept;
      pipeC[0] <= chopNew;
      pipeB[0] <= wrBank;
      for (int k = 1; k < DEPTH; k++) begin
        pipeV[k] <= pipeV[k-1];
        pipeC[k] <= pipeC[k-1];
        pipeB[k] <= pipeB[k-1];
      end
    end
  end

  // Period roles decoded from the token line.
  always_comb begin
    beatOn  = 1'b0;
    pair    = 2'd0;
    curChop = 1'b0;
    for (int j = 0; j < BURST_CLKS; j++) begin
      if (pipeV[WL+j]) begin
        beatOn  = 1'b1;
        pair    = 2'(j);
        curChop = pipeC[WL+j];
      end
    end
    pre  = pipeV[PRE_AT];
    post = pipeV[POST_AT] && !pre;   // a following preamble overrides the postamble
  end

  assign dqsOe = pre || beatOn || post;
  assign dqOe  = dqsOe;
  assign dqs   = (pre || beatOn) ? 2'b01 : 2'b00;
  assign dqsN  = dqsOe ? ~dqs : 2'b00;

  always_comb begin
    strobes         = '0;
    strobes.capture = accept;
    strobes.launch  = pre;
    strobes.beatOn  = beatOn;
    strobes.pair    = pair;
    strobes.chop    = curChop;
  end

  // Per-bank write recovery, started on the edge that ends the last data period.
  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [CW-1:0] recCnt;
    logic          inFlight;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) recCnt <= '0;
      else if (pipeV[END_AT] && pipeB[END_AT] == BANK_W'(b)) recCnt <= CW'(WR);
      else if (recCnt != '0) recCnt <= recCnt - 1'b1;
    end

    always_comb begin
      inFlight = 1'b0;
      for (int k = 0; k <= END_AT; k++)
        if (pipeV[k] && pipeB[k] == BANK_W'(b)) inFlight = 1'b1;
    end

    assign pchReady[b] = !inFlight && (recCnt == '0);
  end

endmodule

// File: rtl/ddr_wr_data.sv
module ddr_wr_data
  import ddr_wr_pkg::*;
#(
  parameter  int WL   = 5,
  parameter  int DQ_W = 8,
  localparam int DM_W = (DQ_W + 7) / 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobe_t             strobes,
  input  logic [BEATS*DQ_W-1:0] wrData,
  input  logic [BEATS*DM_W-1:0] wrMask,
  output logic [DQ_W-1:0]       dqEven,
  output logic [DQ_W-1:0]       dqOdd,
  output logic [DM_W-1:0]       dmEven,
  output logic [DM_W-1:0]       dmOdd
);

  logic [BEATS*DQ_W-1:0] stD [WL];
  logic [BEATS*DM_W-1:0] stM [WL];
  logic [BEATS*DQ_W-1:0] burstD;
  logic [BEATS*DM_W-1:0] burstM;
  logic                  dropPair;
  int                    beatE;

  // Payload travels alongside its token; stage k holds it in the k-th period.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < WL; k++) begin
        stD[k] <= '0;
        stM[k] <= '1;
      end
    end else begin
      if (strobes.capture) begin
        stD[0] <= wrData;
        stM[0] <= wrMask;
      end
      for (int k = 1; k < WL; k++) begin
        stD[k] <= stD[k-1];
        stM[k] <= stM[k-1];
      end
    end
  end

  // The burst register is loaded at the end of the preamble period.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      burstD <= '0;
      burstM <= '1;
    end else if (strobes.launch) begin
      burstD <= stD[WL-1];
      burstM <= stM[WL-1];
    end
  end

  always_comb begin
    beatE    = 2 * int'(strobes.pair);
    dropPair = strobes.chop && strobes.pair[1];
    dqEven   = '0;
    dqOdd    = '0;
    dmEven   = '1;
    dmOdd    = '1;
    if (strobes.beatOn && !dropPair) begin
      dqEven = burstD[beatE*DQ_W +: DQ_W];
      dqOdd  = burstD[(beatE+1)*DQ_W +: DQ_W];
      dmEven = burstM[beatE*DM_W +: DM_W];
      dmOdd  = burstM[(beatE+1)*DM_W +: DM_W];
    end
  end

endmodule

// File: rtl/ddr_wr_burst_seq.sv
module ddr_wr_burst_seq
  import ddr_wr_pkg::*;
#(
  parameter  int WL     = 5,
  parameter  int WR     = 10,
  parameter  int BANK_W = 3,
  parameter  int DQ_W   = 8,
  localparam int DM_W   = (DQ_W + 7) / 8,
  localparam int NB     = 1 << BANK_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrCmd,
  input  logic [BANK_W-1:0]     wrBank,
  input  logic [1:0]            burstField,
  input  logic                  addr12,
  input  logic [BEATS*DQ_W-1:0] wrData,
  input  logic [BEATS*DM_W-1:0] wrMask,
  output logic                  wrReady,
  output logic [1:0]            dqs,
  output logic [1:0]            dqsN,
  output logic                  dqsOe,
  output logic                  dqOe,
  output logic [DQ_W-1:0]       dqEven,
  output logic [DQ_W-1:0]       dqOdd,
  output logic [DM_W-1:0]       dmEven,
  output logic [DM_W-1:0]       dmOdd,
  output logic [NB-1:0]         pchReady
);

  dpStrobe_t strobes;

  ddr_wr_ctrl #(.WL(WL), .WR(WR), .BANK_W(BANK_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrCmd(wrCmd), .wrBank(wrBank),
    .burstField(burstField), .addr12(addr12), .wrReady(wrReady),
    .dqs(dqs), .dqsN(dqsN), .dqsOe(dqsOe), .dqOe(dqOe),
    .pchReady(pchReady), .strobes(strobes)
  );

  ddr_wr_data #(.WL(WL), .DQ_W(DQ_W)) data_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .wrMask(wrMask), .dqEven(dqEven), .dqOdd(dqOdd),
    .dmEven(dmEven), .dmOdd(dmOdd)
  );

endmodule

// File: rtl/ddr_wr_burst_seq_chk.sv
module ddr_wr_burst_seq_chk #(
  parameter  int WL     = 5,
  parameter  int WR     = 10,
  parameter  int BANK_W = 3,
  parameter  int DQ_W   = 8,
  localparam int DM_W   = (DQ_W + 7) / 8,
  localparam int NB     = 1 << BANK_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrCmd,
  input logic [BANK_W-1:0] wrBank,
  input logic              wrReady,
  input logic [1:0]        dqs,
  input logic [1:0]        dqsN,
  input logic              dqsOe,
  input logic              dqOe,
  input logic [DQ_W-1:0]   dqEven,
  input logic [DQ_W-1:0]   dqOdd,
  input logic [DM_W-1:0]   dmEven,
  input logic [DM_W-1:0]   dmOdd,
  input logic [NB-1:0]     pchReady
);

  AST_READY_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (wrCmd && wrReady) |=> !wrReady);  // R8

  AST_PCH_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (wrCmd && wrReady) |=> !pchReady[$past(wrBank)]);  // R10

  AST_PRE_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dqsOe) |-> (dqs == 2'b01 && dmEven == '1 && dmOdd == '1));  // R3

  AST_POST_LAST: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dqsOe) |-> ($past(dqs) == 2'b00));  // R5

  AST_STROBE_COMPL: assert property (@(posedge clk) disable iff (!rstN)
    dqsOe |-> (dqsN == ~dqs));  // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !dqOe |-> (dqs == 2'b00 && dqsN == 2'b00 && dqEven == '0 && dqOdd == '0
               && dmEven == '1 && dmOdd == '1));  // R11

endmodule

bind ddr_wr_burst_seq ddr_wr_burst_seq_chk #(.WL(WL), .WR(WR), .BANK_W(BANK_W), .DQ_W(DQ_W)) chk_i (
  .clk(clk), .rstN(rstN), .wrCmd(wrCmd), .wrBank(wrBank), .wrReady(wrReady),
  .dqs(dqs), .dqsN(dqsN), .dqsOe(dqsOe), .dqOe(dqOe), .dqEven(dqEven),
  .dqOdd(dqOdd), .dmEven(dmEven), .dmOdd(dmOdd), .pchReady(pchReady)
);

// File: tb/ddr_wr_burst_seq_tb.sv
module ddr_wr_burst_seq_tb_top;

  localparam int WL = 5, WR = 10, BANK_W = 3, DQ_W = 8, DM_W = 1, NB = 8;
  localparam int MAXC = 2048;

  logic              clk, rstN, wrCmd, addr12;
  logic [BANK_W-1:0] wrBank;
  logic [1:0]        burstField;
  logic [63:0]       wrData;
  logic [7:0]        wrMask;
  logic              wrReady, dqsOe, dqOe;
  logic [1:0]        dqs, dqsN;
  logic [7:0]        dqEven, dqOdd;
  logic [0:0]        dmEven, dmOdd;
  logic [NB-1:0]     pchReady;

  ddr_wr_burst_seq #(.WL(WL), .WR(WR), .BANK_W(BANK_W), .DQ_W(DQ_W)) dut_i (
    .clk(clk), .rstN(rstN), .wrCmd(wrCmd), .wrBank(wrBank), .burstField(burstField),
    .addr12(addr12), .wrData(wrData), .wrMask(wrMask), .wrReady(wrReady),
    .dqs(dqs), .dqsN(dqsN), .dqsOe(dqsOe), .dqOe(dqOe), .dqEven(dqEven),
    .dqOdd(dqOdd), .dmEven(dmEven), .dmOdd(dmOdd), .pchReady(pchReady)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0, fails = 0, s = 0, nCmd = 0;
  int          cmdEdge [MAXC];
  bit          cmdChop [MAXC];
  bit          cmdTagR2 [MAXC];
  logic [2:0]  cmdBank [MAXC];
  logic [63:0] cmdData [MAXC];
  logic [7:0]  cmdMask [MAXC];
  bit          expReady;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s slot %0d actual=%0h expected=%0h", tag, s, act, exp);
    end
  endtask

  function automatic bit chopOf(input logic [1:0] bf, input logic a12);
    return (bf == 2'b01) && !a12;
  endfunction

  task automatic checkSlot();
    bit pre = 0, dat = 0, post = 0, chop = 0, oe, drop;
    int pair = 0, ci = 0, e;
    logic [1:0] eDqs, eDqsN;
    logic [7:0] eDqE = 0, eDqO = 0;
    logic eDmE = 1, eDmO = 1;
    logic [NB-1:0] ePch = '1;
    string tagS, tagD;
    expReady = 1;
    for (int i = (nCmd > 8 ? nCmd - 8 : 0); i < nCmd; i++) begin
      int k = s - cmdEdge[i];
      if (k <= 3) expReady = 0;
      if (k <= WL + 3 + WR) ePch[cmdBank[i]] = 1'b0;
      if (k == WL - 1) pre = 1;
      if (k >= WL && k <= WL + 3) begin dat = 1; pair = k - WL; ci = i; end
      if (k == WL + 4) post = 1;
    end
    oe    = pre || dat || post;
    eDqs  = (pre || dat) ? 2'b01 : 2'b00;
    eDqsN = oe ? ~eDqs : 2'b00;
    if (dat) begin
      chop = cmdChop[ci];
      drop = chop && pair >= 2;
      e = 2 * pair;
      if (!drop) begin
        eDqE = cmdData[ci][e*8 +: 8];   eDqO = cmdData[ci][(e+1)*8 +: 8];
        eDmE = cmdMask[ci][e];          eDmO = cmdMask[ci][e+1];
      end
    end
    tagS = (pre && post) ? "R9" : pre ? "R3" : dat ? "R4" : post ? "R5" : "R11";
    tagD = !dat ? tagS : chop ? "R7" : cmdTagR2[ci] ? "R2" : "R4";
    chk(dqs === eDqs, tagS, 64'(dqs), 64'(eDqs));
    chk(dqsN === eDqsN, "R6 dqsN", 64'(dqsN), 64'(eDqsN));
    chk(dqsOe === oe && dqOe === oe, (pre && post) ? "R9 oe" : "R6 oe", {dqsOe, dqOe}, {oe, oe});
    chk(dqEven === eDqE && dqOdd === eDqO, tagD, {dqEven, dqOdd}, {eDqE, eDqO});
    chk(dmEven === eDmE && dmOdd === eDmO, tagD, {dmEven, dmOdd}, {eDmE, eDmO});
    chk(wrReady === expReady, "R8 ready", 64'(wrReady), 64'(expReady));
    chk(pchReady === ePch, "R10 pch", 64'(pchReady), 64'(ePch));
  endtask

  task automatic slot(input bit c, input logic [1:0] bf, input logic a12, input logic [2:0] bank);
    @(negedge clk);
    checkSlot();
    wrCmd = c; burstField = bf; addr12 = a12; wrBank = bank;
    wrData = {$urandom, $urandom}; wrMask = 8'($urandom);
    if (c && expReady && nCmd < MAXC) begin
      cmdEdge[nCmd] = s + 1; cmdChop[nCmd] = chopOf(bf, a12);
      cmdTagR2[nCmd] = !chopOf(bf, a12) && (bf == 2'b01 || !a12);
      cmdBank[nCmd] = bank; cmdData[nCmd] = wrData; cmdMask[nCmd] = wrMask;
      nCmd++;
    end
    s++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) slot(0, 2'b00, 1'b1, 3'd0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rstN = 0; wrCmd = 0; wrBank = 0; burstField = 0; addr12 = 1; wrData = 0; wrMask = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(dqsOe === 0 && dqOe === 0 && dqs === 2'b00 && dqsN === 2'b00, "R1 strobe", {dqsOe, dqOe, dqs, dqsN}, 0);
      chk(dqEven === 0 && dqOdd === 0 && dmEven === 1 && dmOdd === 1, "R1 beats", {dqEven, dqOdd, dmEven, dmOdd}, 3);
      chk(wrReady === 1 && pchReady === '1, "R1 ready", {wrReady, pchReady}, 9'h1ff);
    end
    rstN = 1;
    idle(2);
    // Directed: chop decode over all four field/bit combinations (R2, R7)
    slot(1, 2'b00, 1'b0, 3'd3); idle(25);
    slot(1, 2'b01, 1'b0, 3'd2); idle(25);
    slot(1, 2'b01, 1'b1, 3'd1); idle(25);
    slot(1, 2'b10, 1'b0, 3'd5); idle(1);
    // R8: commands inside the refusal window must be ignored
    slot(1, 2'b01, 1'b0, 3'd6); slot(1, 2'b00, 1'b0, 3'd7); idle(25);
    // R9: five edges apart, same bank, preamble over postamble
    slot(1, 2'b00, 1'b0, 3'd4); idle(4);
    slot(1, 2'b01, 1'b0, 3'd4); idle(4);
    slot(1, 2'b00, 1'b1, 3'd0); idle(30);
    // Constrained random phase
    for (int i = 0; i < 3000; i++)
      slot(($urandom % 4) == 0, 2'($urandom), 1'($urandom), 3'($urandom));
    idle(30);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired at slot %0d actual=hung expected=done", s);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule